// File: doc/BRIEF.md
# Banked Index/Data Configuration Register File

This block holds the configuration state of a multi-function peripheral chip. The host sees only two byte-wide ports. Port 0 is a pointer: it chooses a register. Port 1 is a window: it reads or writes the register that the pointer chooses. The pointer space has three regions. Location 07h holds a device selector. Locations 20h to 2Fh are shared by the whole chip. Every location from 30h upward belongs to the logical device that the selector currently names. The banked regions of nine devices therefore share one index range, and the host must write the selector before it can reach a device's registers.

Each device bank implements the same layout:
- an activation byte at 30h
- four address bytes at 60h to 63h
- two interrupt bytes at 70h and 71h
- two DMA bytes at 74h and 75h
- fifteen vendor bytes at F0h to FEh

Any other location is unimplemented. It ignores writes and returns a fixed default on reads. That default is 00h everywhere except at the two DMA bytes, where it is 04h, meaning "no channel". The register file is usable straight out of reset, with no unlock step.

Top module: `cfg_regfile_top`

## Requirements
- R1: A write with `port_sel`=0 loads the pointer with `wdata`. A read with `port_sel`=0 returns the pointer. The pointer changes on no other access.
- R2: A port-1 access while the pointer is 07h reads or writes the 8-bit device selector. Any value can be stored, including reserved ones.
- R3: Pointer values 20h to 2Fh reach sixteen shared bytes. These bytes are the same whatever the device selector holds.
- R4: Pointer values of 30h and above reach the bank of the selected device. The nine valid selector values are 00h, 01h, 02h, 03h, 07h, 0Ah, 0Bh, 0Ch and 0Fh. Each bank has its own storage.
- R5: In each bank, 30h, 60h to 63h, 70h, 71h, 74h, 75h and F0h to FEh are readable and writable bytes.
- R6: Unimplemented locations ignore port-1 writes and read 00h. These are pointer values 00h to 06h, 08h to 1Fh, and any location of 30h or above that R5 does not list.
- R7: While the selector holds a reserved value, port-1 accesses at 30h and above write nothing. They read 04h at 74h and 75h, and 00h everywhere else.
- R8: After reset, the following hold:
  - the pointer, the selector, the shared bytes and `rdata` are 00h;
  - every banked byte is 00h, except 74h and 75h, which are 04h.
- R9: `rdata` is loaded on the clock edge that samples `rd_en`, so it is valid one cycle after the strobe. It keeps its value while `rd_en` is low.
- R10: If `wr_en` and `rd_en` are both high in one cycle, the read returns the value as it was before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_sel | input | 1 | 0 selects the pointer port, 1 selects the data window |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A write takes effect on the edge that samples it. A later access is therefore the earliest point where the bench can observe the write. A read answers on that same edge, through the single `rdata` register.

The bench drives each strobe for exactly one cycle, from the falling edge. It compares `rdata` at the next falling edge, half a period after the edge that loaded it. For the holding rule, the bench first does non-read accesses and idle cycles. It then re-samples `rdata` to confirm that the value did not move. For the simultaneous case, it checks the returned value on the following falling edge against the pre-write contents.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int DW     = 8;
    localparam int NBANK  = 9;
    localparam int NSLOT  = 24;
    localparam int NGLOB  = 16;
    localparam int BW     = $clog2(NBANK);
    localparam int SW     = $clog2(NSLOT);
    localparam int GW     = $clog2(NGLOB);

    localparam logic [DW-1:0] IDX_SEL    = 8'h07;
    localparam logic [DW-1:0] GLOB_LO    = 8'h20;
    localparam logic [DW-1:0] GLOB_HI    = 8'h2F;
    localparam logic [DW-1:0] BANK_LO    = 8'h30;
    localparam logic [DW-1:0] DMA_IDLE   = 8'h04;

    // selector code of bank b sits at bits [b*DW +: DW]
    localparam logic [NBANK*DW-1:0] SEL_CODES =
        {8'h0F, 8'h0C, 8'h0B, 8'h0A, 8'h07, 8'h03, 8'h02, 8'h01, 8'h00};

    // slot numbers of the two DMA bytes inside a bank
    localparam int SLOT_DMA0 = 7;
    localparam int SLOT_DMA1 = 8;

    function automatic logic [DW-1:0] slot_default(input int slot);
        return (slot == SLOT_DMA0 || slot == SLOT_DMA1) ? DMA_IDLE : '0;
    endfunction

    typedef struct packed {
        logic [DW-1:0]            ptr;
        logic [DW-1:0]            sel;
        logic [NGLOB-1:0][DW-1:0] glob;
        logic [DW-1:0]            rdata;
    } cfg_state_t;

endpackage

// File: rtl/cfg_sel_decode.sv
module cfg_sel_decode
    import cfg_pkg::*;
#(
    parameter int N_BANK = NBANK,
    parameter int B_W    = BW,
    parameter logic [N_BANK*DW-1:0] CODES = SEL_CODES
) (
    input  logic [DW-1:0]  sel,
    output logic [B_W-1:0] bank,
    output logic           valid
);

    logic [N_BANK-1:0] match;

    for (genvar b = 0; b < N_BANK; b++) begin : g_cmp
        assign match[b] = (sel == CODES[b*DW +: DW]);
    end

    always_comb begin
        bank  = '0;
        valid = 1'b0;
        for (int b = 0; b < N_BANK; b++) begin
            if (match[b]) begin
                bank  = B_W'(b);
                valid = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_slot_decode.sv
module cfg_slot_decode
    import cfg_pkg::*;
(
    input  logic [DW-1:0] ptr,
    output logic [SW-1:0] slot,
    output logic          hit,
    output logic          dma
);

    always_comb begin
        slot = '0;
        hit  = 1'b0;
        dma  = (ptr == 8'h74) || (ptr == 8'h75);
        if (ptr == 8'h30) begin
            slot = SW'(0);
            hit  = 1'b1;
        end else if (ptr[7:2] == 6'b0110_00) begin
            slot = SW'(ptr[1:0]) + SW'(1);
            hit  = 1'b1;
        end else if (ptr[7:1] == 7'b0111_000) begin
            slot = SW'(ptr[0]) + SW'(5);
            hit  = 1'b1;
        end else if (ptr[7:1] == 7'b0111_010) begin
            slot = SW'(ptr[0]) + SW'(SLOT_DMA0);
            hit  = 1'b1;
        end else if (ptr[7:4] == 4'hF && ptr[3:0] != 4'hF) begin
            slot = SW'(ptr[3:0]) + SW'(9);
            hit  = 1'b1;
        end
    end

endmodule

// File: rtl/cfg_bank_store.sv
module cfg_bank_store
    import cfg_pkg::*;
#(
    parameter int N_BANK = NBANK,
    parameter int N_SLOT = NSLOT,
    parameter int B_W    = BW,
    parameter int S_W    = SW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [B_W-1:0] bank,
    input  logic [S_W-1:0] slot,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);

    logic [N_BANK-1:0][N_SLOT-1:0][DW-1:0] rows;

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic [N_SLOT-1:0][DW-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (we && bank == B_W'(b)) begin
                row_d[slot] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < N_SLOT; s++) begin
                    row_q[s] <= slot_default(s);
                end
            end else begin
                row_q <= row_d;
            end
        end

        assign rows[b] = row_q;
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < N_BANK; b++) begin
            if (bank == B_W'(b)) begin
                rdata = rows[b][slot];
            end
        end
    end

endmodule

// File: rtl/cfg_regfile_top.sv
module cfg_regfile_top
    import cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    cfg_state_t st_d, st_q;

    logic [BW-1:0] bank_idx;
    logic          sel_ok;
    logic [SW-1:0] slot_idx;
    logic          slot_hit;
    logic          slot_dma;
    logic          bank_we;
    logic [DW-1:0] bank_rd;
    logic [DW-1:0] window_rd;
    logic          in_glob;
    logic          in_bank;

    logic [DW-1:0] ptr_cur;
    logic [DW-1:0] sel_cur;

    assign ptr_cur = st_q.ptr;
    assign sel_cur = st_q.sel;

    cfg_sel_decode u_sel (
        .sel   (st_q.sel),
        .bank  (bank_idx),
        .valid (sel_ok)
    );

    cfg_slot_decode u_slot (
        .ptr  (st_q.ptr),
        .slot (slot_idx),
        .hit  (slot_hit),
        .dma  (slot_dma)
    );

    cfg_bank_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .bank  (bank_idx),
        .slot  (slot_idx),
        .wdata (wdata),
        .rdata (bank_rd)
    );

    assign in_glob = (st_q.ptr >= GLOB_LO) && (st_q.ptr <= GLOB_HI);
    assign in_bank = (st_q.ptr >= BANK_LO);

    // data window read value, from pre-edge state
    always_comb begin
        window_rd = '0;
        if (st_q.ptr == IDX_SEL) begin
            window_rd = st_q.sel;
        end else if (in_glob) begin
            window_rd = st_q.glob[st_q.ptr[GW-1:0]];
        end else if (in_bank) begin
            if (sel_ok && slot_hit) begin
                window_rd = bank_rd;
            end else if (slot_dma) begin
                window_rd = DMA_IDLE;
            end
        end
    end

    always_comb begin
        st_d    = st_q;
        bank_we = 1'b0;
        if (wr_en) begin
            if (!port_sel) begin
                st_d.ptr = wdata;
            end else if (st_q.ptr == IDX_SEL) begin
                st_d.sel = wdata;
            end else if (in_glob) begin
                st_d.glob[st_q.ptr[GW-1:0]] = wdata;
            end else if (in_bank && sel_ok && slot_hit) begin
                bank_we = 1'b1;
            end
        end
        if (rd_en) begin
            st_d.rdata = port_sel ? window_rd : st_q.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       port_sel,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] ptr_cur,
    input logic [7:0] sel_cur
);

    logic sel_legal;
    assign sel_legal = sel_cur inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h07,
                                       8'h0A, 8'h0B, 8'h0C, 8'h0F};

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !port_sel) |=> ptr_cur == $past(wdata)); // R1

    AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !port_sel) |=> $stable(ptr_cur)); // R1

    AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !port_sel) |=> rdata == $past(ptr_cur)); // R1

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port_sel && ptr_cur == 8'h07) |=> sel_cur == $past(wdata)); // R2

    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel && ptr_cur < 8'h20 && ptr_cur != 8'h07) |=> rdata == 8'h00); // R6

    AST_RSV_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && port_sel && ptr_cur >= 8'h30 && !sel_legal) |=>
        rdata == (($past(ptr_cur) == 8'h74 || $past(ptr_cur) == 8'h75) ? 8'h04 : 8'h00)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R9

endmodule

bind cfg_regfile_top cfg_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_sel (port_sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .ptr_cur  (ptr_cur),
    .sel_cur  (sel_cur)
);

// File: tb/sim_cfg_regfile_top.sv
module sim_cfg_regfile_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 45;

    // entry: {is_read, port, data, expect, req}
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h03, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h03, 4'd2},   // R2 selector readback
        {1'b1, 1'b0, 8'h00, 8'h07, 4'd1},   // R1 pointer readback
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd4},
        {1'b0, 1'b1, 8'hA5, 8'h00, 4'd4},
        {1'b1, 1'b1, 8'h00, 8'hA5, 4'd4},   // R4 bank 03h write
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd4},
        {1'b0, 1'b1, 8'h0A, 8'h00, 4'd4},
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd4},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd4},   // R4 bank 0Ah separate
        {1'b0, 1'b1, 8'h3C, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h3C, 4'd5},   // R5
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd4},
        {1'b0, 1'b1, 8'h03, 8'h00, 4'd4},
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd4},
        {1'b1, 1'b1, 8'h00, 8'hA5, 4'd4},   // R4 bank 03h kept
        {1'b0, 1'b0, 8'h25, 8'h00, 4'd3},
        {1'b0, 1'b1, 8'h77, 8'h00, 4'd3},
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd3},
        {1'b0, 1'b1, 8'h0F, 8'h00, 4'd3},
        {1'b0, 1'b0, 8'h25, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'h77, 4'd3},   // R3 shared across selectors
        {1'b0, 1'b0, 8'hFE, 8'h00, 4'd5},
        {1'b0, 1'b1, 8'h11, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h11, 4'd5},   // R5 last vendor byte
        {1'b0, 1'b0, 8'hFF, 8'h00, 4'd6},
        {1'b0, 1'b1, 8'h99, 8'h00, 4'd6},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd6},   // R6 FFh unimplemented
        {1'b0, 1'b0, 8'h40, 8'h00, 4'd6},
        {1'b0, 1'b1, 8'h55, 8'h00, 4'd6},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd6},   // R6 40h unimplemented
        {1'b0, 1'b0, 8'h10, 8'h00, 4'd6},
        {1'b0, 1'b1, 8'h66, 8'h00, 4'd6},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd6},   // R6 low region
        {1'b0, 1'b0, 8'h75, 8'h00, 4'd8},
        {1'b1, 1'b1, 8'h00, 8'h04, 4'd8},   // R8 DMA default in bank 0Fh
        {1'b0, 1'b1, 8'h02, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h02, 4'd5},   // R5 DMA byte writable
        {1'b0, 1'b0, 8'h71, 8'h00, 4'd5},
        {1'b0, 1'b1, 8'h0E, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h0E, 4'd5},   // R5 interrupt byte
        {1'b0, 1'b0, 8'h30, 8'h00, 4'd5},
        {1'b0, 1'b1, 8'h01, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h01, 4'd5}    // R5 activation byte
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int checks = 0;
    int failures = 0;
    logic [7:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_regfile_top u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_sel (port_sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic put(input logic p, input logic [7:0] d);
        port_sel = p;
        wdata    = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic get(input logic p, input string tag, input logic [7:0] exp);
        port_sel = p;
        rd_en    = 1'b1;
        @(negedge clk);
        rd_en    = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        apply_reset();
        check("R8 rdata after reset", rdata, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][21]) begin
                get(VEC[i][20], $sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][11:4]);
            end else begin
                put(VEC[i][20], VEC[i][19:12]);
            end
        end

        // R7 reserved selector
        put(1'b0, 8'h07); put(1'b1, 8'h05);
        get(1'b1, "R2 reserved value stored", 8'h05);
        put(1'b0, 8'h74);
        get(1'b1, "R7 reserved 74h", 8'h04);
        put(1'b1, 8'h99);
        get(1'b1, "R7 reserved 74h after write", 8'h04);
        put(1'b0, 8'h30); put(1'b1, 8'h5A);
        get(1'b1, "R7 reserved 30h", 8'h00);
        put(1'b0, 8'h07); put(1'b1, 8'h00);
        put(1'b0, 8'h30);
        get(1'b1, "R7 no alias into bank 00h", 8'h00);
        put(1'b0, 8'h74);
        get(1'b1, "R7 no alias into bank 00h DMA", 8'h04);

        // R9 rdata timing and hold
        put(1'b0, 8'h25);
        get(1'b1, "R9 read lands next cycle", 8'h77);
        held = rdata;
        put(1'b0, 8'h60);
        put(1'b1, 8'hC3);
        repeat (3) @(negedge clk);
        check("R9 rdata held without strobe", rdata, held);

        // R10 simultaneous write and read
        port_sel = 1'b1; wdata = 8'h33; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 read returns pre-write value", rdata, 8'hC3);
        get(1'b1, "R10 write took effect", 8'h33);

        // R8 reset restores defaults
        apply_reset();
        check("R8 rdata cleared", rdata, 8'h00);
        get(1'b0, "R8 pointer cleared", 8'h00);
        put(1'b0, 8'h07);
        get(1'b1, "R8 selector cleared", 8'h00);
        put(1'b1, 8'h03); put(1'b0, 8'h60);
        get(1'b1, "R8 bank byte cleared", 8'h00);
        put(1'b0, 8'h75);
        get(1'b1, "R8 DMA byte restored", 8'h04);
        put(1'b0, 8'h25);
        get(1'b1, "R8 shared byte cleared", 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule